// File: doc/BRIEF.md
# SECDED Memory ECC Stage with Error Injection

This block sits in the datapath of a memory controller. On the write side it computes single-error-correct, double-error-detect check bits for every data word. For testing the checker, it can also corrupt one or two data bits on purpose after those check bits are formed. On the read side it checks each returned word together with its stored check bits. It can repair a single flipped bit, and it reports double flips it cannot repair. Both write and read paths have one register stage.

A small word-addressed register port holds a control register, a sticky error status register and a captured error address. One control bit, which clears itself, wipes the status, the address and the interrupt in a single write. The interrupt is gated by a global enable and by a separate mask for each error class. The data width is a parameter with a default of 64 bits, which gives 8 check bits.

Top module: `ecc_secded_ctl`

## Requirements
- R1: After reset the control register (word address 0x130) reads 0x01, with only ECC on set. The status register (0x131) and the error address register (0x132) read 0, and irq is 0.
- R2: With ECC on, each write accepted on wr_valid appears one cycle later on mem_wr_valid and mem_wr_data, together with the code in mem_wr_chk. Data bit i occupies the i-th position, counting from 1, that is not a power of two. Check bit j (j<7) is the XOR of the data bits whose position has bit j set. Check bit 7 is the XOR of all data bits and check bits 0 to 6.
- R3: With ECC on (control bit 0) cleared, written data passes unchanged with mem_wr_chk = 0 and no injection. Reads return rd_data raw, with no error flag and no change to status or address.
- R4: Control bit 2 inverts data bit 0 of each written word, and control bit 3 inverts data bits 0 and 1. Both act after the check bits are formed.
- R5: A read whose data has one flipped bit returns the corrected word, with out_sbe = 1 and out_dbe = 0, when auto-correct (control bit 1) is set. Results appear one cycle after rd_valid.
- R6: With auto-correct cleared, a single-bit error still raises out_sbe, but the raw data is returned.
- R7: A single flipped check bit raises out_sbe and leaves the data unchanged.
- R8: Two flipped bits raise out_dbe with out_sbe = 0, and the raw data is returned.
- R9: Status bit 0 (single error) and bit 1 (double error) become set on a flagged read and stay set until a clear. Writes to 0x131 have no effect.
- R10: Register 0x132 holds the rd_addr of the first flagged read since the last clear or reset. Later errors do not change it.
- R11: irq is 1 exactly when interrupt enable (control bit 4) is set and a set status flag is not masked by its own mask: bit 5 for single, bit 6 for double.
- R12: Writing 1 to control bit 7 clears both status flags, the error address and irq on that write's clock edge. Bit 7 always reads back 0. An error flagged on the same edge is still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| wr_valid | input | 1 | Write word valid |
| wr_data | input | DATA_W | Write data from the controller |
| mem_wr_valid | output | 1 | Encoded write word valid |
| mem_wr_data | output | DATA_W | Data toward memory, after injection |
| mem_wr_chk | output | CHK_W | Check bits toward memory |
| rd_valid | input | 1 | Read word valid |
| rd_addr | input | ADDR_W | Address of the read word |
| rd_data | input | DATA_W | Data returned from memory |
| rd_chk | input | CHK_W | Check bits returned from memory |
| out_valid | output | 1 | Checked read word valid |
| out_data | output | DATA_W | Checked, possibly corrected, data |
| out_sbe | output | 1 | Single-bit error on this word |
| out_dbe | output | 1 | Double-bit error on this word |
| irq | output | 1 | Error interrupt |

## Verification
The bench flips every class of bit: each data position, each check position including the overall parity bit, and pairs of bits. A wrong syndrome-to-position map would repair the wrong bit, and a swapped single/double decision would flag the wrong class. Injection is checked by reading the corrupted word back through the checker. Injecting before encoding would make the corruption invisible to the checker. The bench also checks that the error address stays on the first fault, because a design that overwrites it would show a later address. It checks that clear, masks and the enable each move irq as specified, and that a disabled stage ignores corrupt words.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    // Hamming bits needed to cover dw data bits (overall parity not included)
    function automatic int ham_bits(input int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // Codeword position (1-based) of data bit idx: the idx-th non-power-of-two
    function automatic int data_pos(input int idx);
        int cnt;
        int found;
        cnt   = 0;
        found = 0;
        for (int pos = 3; pos < 4 * idx + 8; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (cnt == idx && found == 0) found = pos;
                cnt++;
            end
        end
        return found;
    endfunction

    localparam logic [11:0] REG_CTRL  = 12'h130;
    localparam logic [11:0] REG_STAT  = 12'h131;
    localparam logic [11:0] REG_EADDR = 12'h132;

    typedef struct packed {
        logic msk_dbe;   // bit 6
        logic msk_sbe;   // bit 5
        logic irq_en;    // bit 4
        logic inj_dbe;   // bit 3
        logic inj_sbe;   // bit 2
        logic auto_fix;  // bit 1
        logic ecc_on;    // bit 0
    } ecc_ctrl_t;

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc #(
    parameter  int DATA_W = 64,
    localparam int HB     = ecc_pkg::ham_bits(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [HB:0]       chk_o
);
    function automatic logic [DATA_W-1:0] col_mask(input int j);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++)
            m[i] = ((ecc_pkg::data_pos(i) >> j) & 1) != 0;
        return m;
    endfunction

    logic [HB-1:0] ham;

    for (genvar j = 0; j < HB; j++) begin : g_col
        localparam logic [DATA_W-1:0] MASK = col_mask(j);
        assign ham[j] = ^(data_i & MASK);
    end

    assign chk_o = {^{data_i, ham}, ham};
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec #(
    parameter  int DATA_W = 64,
    localparam int HB     = ecc_pkg::ham_bits(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [HB:0]       chk_i,
    output logic              sng_o,
    output logic              dbl_o,
    output logic [DATA_W-1:0] fix_o
);
    logic [HB:0]   recomp;
    logic [HB-1:0] syn;
    logic          ovr;

    ecc_enc #(.DATA_W(DATA_W)) u_enc (
        .data_i (data_i),
        .chk_o  (recomp)
    );

    // Syndrome over Hamming bits; overall parity of the received word
    assign syn   = recomp[HB-1:0] ^ chk_i[HB-1:0];
    assign ovr   = recomp[HB] ^ chk_i[HB] ^ (^syn);
    assign sng_o = ovr;
    assign dbl_o = !ovr && (syn != '0);

    for (genvar i = 0; i < DATA_W; i++) begin : g_fix
        localparam int POS = ecc_pkg::data_pos(i);
        assign fix_o[i] = data_i[i] ^ (ovr && (syn == HB'(POS)));
    end
endmodule

// File: rtl/ecc_csr.sv
module ecc_csr #(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [11:0]         reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                ev_sbe,
    input  logic                ev_dbe,
    input  logic [ADDR_W-1:0]   ev_addr,
    output ecc_pkg::ecc_ctrl_t  ctrl,
    output logic                sts_sbe,
    output logic                sts_dbe,
    output logic                err_avld,
    output logic [ADDR_W-1:0]   err_addr,
    output logic                clr_write,
    output logic                irq
);
    import ecc_pkg::*;

    typedef struct packed {
        ecc_ctrl_t         ctrl;
        logic              sbe;
        logic              dbe;
        logic              avld;
        logic [ADDR_W-1:0] ea;
    } csr_t;

    csr_t st_d, st_q;
    logic ctrl_we;

    assign ctrl_we   = reg_we && (reg_addr == REG_CTRL);
    assign clr_write = ctrl_we && reg_wdata[7];

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d.ctrl = ecc_ctrl_t'(reg_wdata[6:0]);
            if (reg_wdata[7]) begin
                st_d.sbe  = 1'b0;
                st_d.dbe  = 1'b0;
                st_d.avld = 1'b0;
                st_d.ea   = '0;
            end
        end
        if (ev_sbe) st_d.sbe = 1'b1;
        if (ev_dbe) st_d.dbe = 1'b1;
        if ((ev_sbe || ev_dbe) && !st_d.avld) begin
            st_d.avld = 1'b1;
            st_d.ea   = ev_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q             <= '0;
            st_q.ctrl.ecc_on <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            REG_CTRL:  reg_rdata = {25'd0, st_q.ctrl};
            REG_STAT:  reg_rdata = {30'd0, st_q.dbe, st_q.sbe};
            REG_EADDR: reg_rdata = 32'(st_q.ea);
            default:   reg_rdata = '0;
        endcase
    end

    assign ctrl     = st_q.ctrl;
    assign sts_sbe  = st_q.sbe;
    assign sts_dbe  = st_q.dbe;
    assign err_avld = st_q.avld;
    assign err_addr = st_q.ea;
    assign irq      = st_q.ctrl.irq_en &&
                      ((st_q.sbe && !st_q.ctrl.msk_sbe) ||
                       (st_q.dbe && !st_q.ctrl.msk_dbe));
endmodule

// File: rtl/ecc_secded_ctl.sv
module ecc_secded_ctl #(
    parameter  int DATA_W = 64,
    parameter  int ADDR_W = 32,
    localparam int CHK_W  = ecc_pkg::ham_bits(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mem_wr_valid,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic [CHK_W-1:0]  mem_wr_chk,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_chk,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sbe,
    output logic              out_dbe,
    output logic              irq
);
    import ecc_pkg::*;

    typedef struct packed {
        logic              wv;
        logic [DATA_W-1:0] wd;
        logic [CHK_W-1:0]  wc;
        logic              rv;
        logic [DATA_W-1:0] rd;
        logic              rs;
        logic              rdb;
    } pipe_t;

    pipe_t             pp_d, pp_q;
    ecc_ctrl_t         ctrl;
    logic              sts_sbe, sts_dbe, err_avld, clr_write;
    logic [ADDR_W-1:0] err_addr;
    logic [CHK_W-1:0]  enc_chk;
    logic              dec_sng, dec_dbl;
    logic [DATA_W-1:0] dec_fix;
    logic              ev_sbe, ev_dbe;
    logic [DATA_W-1:0] inj_mask;

    ecc_enc #(.DATA_W(DATA_W)) u_enc (
        .data_i (wr_data),
        .chk_o  (enc_chk)
    );

    ecc_dec #(.DATA_W(DATA_W)) u_dec (
        .data_i (rd_data),
        .chk_i  (rd_chk),
        .sng_o  (dec_sng),
        .dbl_o  (dec_dbl),
        .fix_o  (dec_fix)
    );

    ecc_csr #(.ADDR_W(ADDR_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev_sbe    (ev_sbe),
        .ev_dbe    (ev_dbe),
        .ev_addr   (rd_addr),
        .ctrl      (ctrl),
        .sts_sbe   (sts_sbe),
        .sts_dbe   (sts_dbe),
        .err_avld  (err_avld),
        .err_addr  (err_addr),
        .clr_write (clr_write),
        .irq       (irq)
    );

    assign ev_sbe = rd_valid && ctrl.ecc_on && dec_sng;
    assign ev_dbe = rd_valid && ctrl.ecc_on && dec_dbl;

    always_comb begin
        inj_mask    = '0;
        inj_mask[0] = ctrl.inj_sbe || ctrl.inj_dbe;
        inj_mask[1] = ctrl.inj_dbe;
    end

    always_comb begin
        pp_d    = pp_q;
        pp_d.wv = wr_valid;
        pp_d.rv = rd_valid;
        if (wr_valid) begin
            if (ctrl.ecc_on) begin
                pp_d.wd = wr_data ^ inj_mask;
                pp_d.wc = enc_chk;
            end else begin
                pp_d.wd = wr_data;
                pp_d.wc = '0;
            end
        end
        if (rd_valid) begin
            pp_d.rs  = ev_sbe;
            pp_d.rdb = ev_dbe;
            pp_d.rd  = (ev_sbe && ctrl.auto_fix) ? dec_fix : rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    assign mem_wr_valid = pp_q.wv;
    assign mem_wr_data  = pp_q.wd;
    assign mem_wr_chk   = pp_q.wc;
    assign out_valid    = pp_q.rv;
    assign out_data     = pp_q.rd;
    assign out_sbe      = pp_q.rs;
    assign out_dbe      = pp_q.rdb;
endmodule

// File: rtl/ecc_secded_ctl_chk.sv
module ecc_secded_ctl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              mem_wr_valid,
    input logic              rd_valid,
    input logic              ecc_on,
    input logic              irq_en,
    input logic              out_sbe,
    input logic              out_dbe,
    input logic              sts_sbe,
    input logic              sts_dbe,
    input logic              err_avld,
    input logic [ADDR_W-1:0] err_addr,
    input logic              clr_write,
    input logic              irq
);
    a_r2_write_latency: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> mem_wr_valid);

    a_r3_bypass_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !ecc_on) |=> (!out_sbe && !out_dbe));

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_sbe && out_dbe));

    a_r9_sbe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_sbe && !clr_write) |=> sts_sbe);

    a_r9_dbe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_dbe && !clr_write) |=> sts_dbe);

    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_avld && !clr_write) |=> $stable(err_addr));

    a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && (sts_sbe || sts_dbe)));

    a_r12_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_write && !rd_valid) |=> (!sts_sbe && !sts_dbe && !irq && err_addr == '0));
endmodule

bind ecc_secded_ctl ecc_secded_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .mem_wr_valid (mem_wr_valid),
    .rd_valid     (rd_valid),
    .ecc_on       (ctrl.ecc_on),
    .irq_en       (ctrl.irq_en),
    .out_sbe      (out_sbe),
    .out_dbe      (out_dbe),
    .sts_sbe      (sts_sbe),
    .sts_dbe      (sts_dbe),
    .err_avld     (err_avld),
    .err_addr     (err_addr),
    .clr_write    (clr_write),
    .irq          (irq)
);

// File: tb/ecc_secded_ctl_tb_top.sv
module ecc_secded_ctl_tb_top;
    localparam int DW = 64;
    localparam int CW = 8;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          mem_wr_valid;
    logic [DW-1:0] mem_wr_data;
    logic [CW-1:0] mem_wr_chk;
    logic          rd_valid = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data = '0;
    logic [CW-1:0] rd_chk = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_sbe, out_dbe, irq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    ecc_secded_ctl #(.DATA_W(DW), .ADDR_W(AW)) dut_i (.*);

    function automatic logic [7:0] ref_chk(input logic [63:0] d);
        logic [71:1] cw;
        logic [7:0]  c;
        int k;
        cw = '0;
        k  = 0;
        for (int p = 1; p <= 71; p++)
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[k];
                k++;
            end
        c = '0;
        for (int j = 0; j < 7; j++)
            for (int p = 1; p <= 71; p++)
                if (((p >> j) & 1) != 0) c[j] = c[j] ^ cw[p];
        c[7] = (^d) ^ (^c[6:0]);
        return c;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_wr(input logic [11:0] a, input logic [7:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [11:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic do_wr(input logic [63:0] d, output logic [63:0] md, output logic [7:0] mc);
        wr_valid = 1'b1; wr_data = d;
        tick();
        wr_valid = 1'b0;
        check("R2", {63'd0, mem_wr_valid}, 64'd1);
        md = mem_wr_data;
        mc = mem_wr_chk;
    endtask

    task automatic do_rd(input logic [31:0] a, input logic [63:0] d, input logic [7:0] c,
                         output logic [63:0] od, output logic s, output logic db);
        rd_valid = 1'b1; rd_addr = a; rd_data = d; rd_chk = c;
        tick();
        rd_valid = 1'b0;
        check("R5", {63'd0, out_valid}, 64'd1);
        od = out_data; s = out_sbe; db = out_dbe;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        logic [63:0] d, md, od;
        logic [7:0]  mc;
        logic        s, db;
        void'($urandom(32'd1234));

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1 reset values
        reg_rd(12'h130, rv); check("R1", 64'(rv), 64'h1);
        reg_rd(12'h131, rv); check("R1", 64'(rv), 64'h0);
        reg_rd(12'h132, rv); check("R1", 64'(rv), 64'h0);
        check("R1", {63'd0, irq}, 64'd0);

        reg_wr(12'h130, 8'h03);

        // R2 encoding with random and directed words
        for (int n = 0; n < 24; n++) begin
            d = (n == 0) ? 64'h0 : (n == 1) ? '1 : (n == 2) ? 64'h1 :
                {$urandom(), $urandom()};
            do_wr(d, md, mc);
            check("R2", md, d);
            check("R2", 64'(mc), 64'(ref_chk(d)));
        end

        // R2 clean read: no flag
        d = {$urandom(), $urandom()};
        do_rd(32'h10, d, ref_chk(d), od, s, db);
        check("R2", od, d);
        check("R2", {62'd0, s, db}, 64'd0);

        // R5 single data-bit correction on every data bit
        for (int b = 0; b < 64; b++) begin
            d = {$urandom(), $urandom()};
            do_rd(32'h20, d ^ (64'd1 << b), ref_chk(d), od, s, db);
            check("R5", od, d);
            check("R5", {62'd0, s, db}, 64'd2);
        end

        // R7 single check-bit error, including overall parity bit
        for (int b = 0; b < 8; b++) begin
            d = {$urandom(), $urandom()};
            do_rd(32'h21, d, ref_chk(d) ^ (8'd1 << b), od, s, db);
            check("R7", od, d);
            check("R7", {62'd0, s, db}, 64'd2);
        end

        // R8 double errors: data-data and data-check
        for (int n = 0; n < 16; n++) begin
            int b1, b2;
            d  = {$urandom(), $urandom()};
            b1 = $urandom_range(0, 63);
            b2 = (b1 + 1 + $urandom_range(0, 62)) % 64;
            do_rd(32'h22, d ^ (64'd1 << b1) ^ (64'd1 << b2), ref_chk(d), od, s, db);
            check("R8", od, d ^ (64'd1 << b1) ^ (64'd1 << b2));
            check("R8", {62'd0, s, db}, 64'd1);
        end
        d = 64'h0123_4567_89ab_cdef;
        do_rd(32'h23, d ^ 64'h8, ref_chk(d) ^ 8'h04, od, s, db);
        check("R8", {62'd0, s, db}, 64'd1);
        check("R8", od, d ^ 64'h8);

        // R9 status sticky and read-only
        reg_rd(12'h131, rv); check("R9", 64'(rv), 64'h3);
        reg_wr(12'h131, 8'h00);
        reg_rd(12'h131, rv); check("R9", 64'(rv), 64'h3);
        // R10 first flagged address since reset was 0x20
        reg_rd(12'h132, rv); check("R10", 64'(rv), 64'h20);

        // R12 clear: status, address zeroed; bit 7 reads 0
        reg_wr(12'h130, 8'h83);
        reg_rd(12'h131, rv); check("R12", 64'(rv), 64'h0);
        reg_rd(12'h132, rv); check("R12", 64'(rv), 64'h0);
        reg_rd(12'h130, rv); check("R12", 64'(rv), 64'h03);

        // R10 capture first, hold on later errors
        d = {$urandom(), $urandom()};
        do_rd(32'h100, d, ref_chk(d), od, s, db);
        do_rd(32'h200, d ^ 64'h40, ref_chk(d), od, s, db);
        do_rd(32'h300, d ^ 64'h3, ref_chk(d), od, s, db);
        reg_rd(12'h132, rv); check("R10", 64'(rv), 64'h200);
        reg_rd(12'h131, rv); check("R9", 64'(rv), 64'h3);

        // R11 interrupt gating
        check("R11", {63'd0, irq}, 64'd0);
        reg_wr(12'h130, 8'h13);
        check("R11", {63'd0, irq}, 64'd1);
        reg_wr(12'h130, 8'h33);
        check("R11", {63'd0, irq}, 64'd1);
        reg_wr(12'h130, 8'h73);
        check("R11", {63'd0, irq}, 64'd0);
        reg_wr(12'h130, 8'hB3);  // clear, keep sbe masked, irq enabled
        check("R12", {63'd0, irq}, 64'd0);
        d = {$urandom(), $urandom()};
        do_rd(32'h400, d ^ 64'h10, ref_chk(d), od, s, db);
        check("R11", {63'd0, irq}, 64'd0);
        reg_wr(12'h130, 8'h13);
        check("R11", {63'd0, irq}, 64'd1);

        // R12 error on the same edge as clear is kept
        reg_we = 1'b1; reg_addr = 12'h130; reg_wdata = 8'h83;
        rd_valid = 1'b1; rd_addr = 32'h500; rd_data = d ^ 64'h5; rd_chk = ref_chk(d);
        tick();
        reg_we = 1'b0; rd_valid = 1'b0;
        reg_rd(12'h131, rv); check("R12", 64'(rv), 64'h2);
        reg_rd(12'h132, rv); check("R12", 64'(rv), 64'h500);
        reg_wr(12'h130, 8'h83);

        // R6 auto-correct off returns raw data
        reg_wr(12'h130, 8'h01);
        d = {$urandom(), $urandom()};
        do_rd(32'h600, d ^ 64'h8000_0000_0000_0000, ref_chk(d), od, s, db);
        check("R6", od, d ^ 64'h8000_0000_0000_0000);
        check("R6", {62'd0, s, db}, 64'd2);

        // R4 injection after encoding
        reg_wr(12'h130, 8'h07);
        d = {$urandom(), $urandom()};
        do_wr(d, md, mc);
        check("R4", md, d ^ 64'h1);
        check("R4", 64'(mc), 64'(ref_chk(d)));
        reg_wr(12'h130, 8'h03);
        do_rd(32'h700, md, mc, od, s, db);
        check("R4", od, d);
        check("R4", {62'd0, s, db}, 64'd2);
        reg_wr(12'h130, 8'h0B);
        do_wr(d, md, mc);
        check("R4", md, d ^ 64'h3);
        check("R4", 64'(mc), 64'(ref_chk(d)));
        reg_wr(12'h130, 8'h03);
        do_rd(32'h701, md, mc, od, s, db);
        check("R4", {62'd0, s, db}, 64'd1);

        // R3 bypass: no check bits, no injection, raw read, no status change
        reg_wr(12'h130, 8'h83);
        reg_wr(12'h130, 8'h0E);
        d = {$urandom(), $urandom()};
        do_wr(d, md, mc);
        check("R3", md, d);
        check("R3", 64'(mc), 64'h0);
        do_rd(32'h800, d ^ 64'h3, 8'h5A, od, s, db);
        check("R3", od, d ^ 64'h3);
        check("R3", {62'd0, s, db}, 64'd0);
        reg_rd(12'h131, rv); check("R3", 64'(rv), 64'h0);
        reg_rd(12'h132, rv); check("R3", 64'(rv), 64'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule